// File: doc/BRIEF.md
# Normalising Barrel Shifter

This block shifts a 16-bit word by a 4-bit amount under the control of a 4-bit operation code. It offers zero-filling shifts in both directions, sign-filling right shifts, and rotates in both directions. The amount comes from one of several places: the shift-amount port, one of two programmable amount registers (called A and B here), or a built-in leading-bit encoder. The encoder counts how far a word must move left to be normalised. The normalise operations shift by that count, and they can store the count in register A or B and drive it out on the amount port.

The block is a two-stage pipeline. At a rising edge it latches the operation code, the data word, the amount port and the port lock. It executes during the following cycle. The next edge writes the result into the data output register and updates the amount registers. The amount port has two directions. An input side is always sampled. An output side consists of an enable plus a value, and the enable is high only while a normalise operation executes with the lock low. A synchronous clear empties both stages and both amount registers.

Top module: `norm_shifter`

## Requirements
- R1: An operation, data word and amount presented before rising edge n are latched at edge n. Their result appears on `data_out` after edge n+1. A new operation can be issued on every edge. Operation codes: 0 zero-fill right by port, 1 zero-fill left by port, 2 rotate right by port, 3 rotate left by port, 4 zero-fill right by A, 5 zero-fill left by A, 6 zero-fill right by B, 7 zero-fill left by B, 8 load A from port, 9 load B from port, 10 sign-fill right by port, 11 sign-fill right by A, 12 sign-fill right by B, 13 normalise, 14 normalise and store count in A, 15 normalise and store count in B.
- R2: Codes 0 and 1 move the word by the latched port amount (0 to 15). Bits that leave the word are lost, and vacated positions are filled with zero.
- R3: Codes 2 and 3 rotate the word by the latched port amount. Bits that leave one end re-enter at the other end.
- R4: Code 10 shifts right by the latched port amount and fills vacated positions with copies of the input's bit 15.
- R5: Codes 4 to 7, 11 and 12 use the current value of register A or B. A value loaded by the operation issued on the previous edge is already in effect.
- R6: Codes 8 and 9 copy the latched port amount into A or B, respectively. While they execute, `data_out` receives the data word unshifted.
- R7: Codes 13 to 15 compute a count equal to the number of bits directly below bit 15 that equal bit 15. The count is at most 15, so 0x0000 and 0xFFFF both give 15. The word is then shifted left by that count with zero fill.
- R8: Code 14 stores the count in A and code 15 stores it in B. Code 13 and every code other than 8, 9, 14 and 15 leave both registers unchanged.
- R9: `amt_oe` is high exactly in the execute cycle of codes 13 to 15, and only when the lock latched with that code is low. `amt_out` then carries the count, and it is zero otherwise.
- R10: `clr` high at an edge zeroes `data_out`, A, B and the latched operation (code 0 with data 0). In the following cycle `amt_oe` is low and both amount registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr | input | 1 | Synchronous clear of both stages and the amount registers |
| data_in | input | 16 | Word to be shifted |
| op_in | input | 4 | Operation code (see R1) |
| amt_in | input | 4 | Input side of the shift-amount port |
| amt_lock | input | 1 | High forces the amount port to input only |
| amt_out | output | 4 | Output side of the amount port: normalise count |
| amt_oe | output | 1 | Drive enable for the amount port |
| data_out | output | 16 | Registered shifted word |

## Verification
The assertions check the following on every cycle. The port drive enable appears only for an unlocked normalise. Register A and register B change only under their own load or store codes. A load passes the data word unchanged. Every normalised result is zero or has differing top two bits. A rotate keeps the number of set bits. A clear empties the output and both registers. The exact values can only be shown by the bench's scenarios, which compare against a reference model. These scenarios cover every amount for each shift kind, the encoder count for zero, all-ones and each single-bit word, and a register loaded on one edge being used by the operation on the next.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

    // Operation codes; the numeric order is the external encoding.
    typedef enum logic [3:0] {
        OP_SRL_V  = 4'd0,
        OP_SLL_V  = 4'd1,
        OP_ROR_V  = 4'd2,
        OP_ROL_V  = 4'd3,
        OP_SRL_A  = 4'd4,
        OP_SLL_A  = 4'd5,
        OP_SRL_B  = 4'd6,
        OP_SLL_B  = 4'd7,
        OP_LDA_V  = 4'd8,
        OP_LDB_V  = 4'd9,
        OP_SRA_V  = 4'd10,
        OP_SRA_A  = 4'd11,
        OP_SRA_B  = 4'd12,
        OP_NORM   = 4'd13,
        OP_NORM_A = 4'd14,
        OP_NORM_B = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SK_LOGIC,
        SK_ARITH,
        SK_ROTATE,
        SK_PASS
    } shk_e;

    typedef enum logic [1:0] {
        AS_PORT,
        AS_REGA,
        AS_REGB,
        AS_PENC
    } asrc_e;

    typedef struct packed {
        shk_e  kind;
        logic  left;
        asrc_e src;
        logic  wr_a;
        logic  wr_b;
        logic  norm;
    } ctl_t;

endpackage

// File: rtl/nsh_decode.sv
module nsh_decode
    import nsh_pkg::*;
(
    input  op_e  op,
    output ctl_t ctl
);

    always_comb begin
        ctl      = '0;
        ctl.kind = SK_LOGIC;
        ctl.src  = AS_PORT;
        unique case (op)
            OP_SRL_V:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_PORT; end
            OP_SLL_V:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_PORT; ctl.left = 1'b1; end
            OP_ROR_V:  begin ctl.kind = SK_ROTATE; ctl.src = AS_PORT; end
            OP_ROL_V:  begin ctl.kind = SK_ROTATE; ctl.src = AS_PORT; ctl.left = 1'b1; end
            OP_SRL_A:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_REGA; end
            OP_SLL_A:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_REGA; ctl.left = 1'b1; end
            OP_SRL_B:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_REGB; end
            OP_SLL_B:  begin ctl.kind = SK_LOGIC;  ctl.src = AS_REGB; ctl.left = 1'b1; end
            OP_LDA_V:  begin ctl.kind = SK_PASS;   ctl.wr_a = 1'b1; end
            OP_LDB_V:  begin ctl.kind = SK_PASS;   ctl.wr_b = 1'b1; end
            OP_SRA_V:  begin ctl.kind = SK_ARITH;  ctl.src = AS_PORT; end
            OP_SRA_A:  begin ctl.kind = SK_ARITH;  ctl.src = AS_REGA; end
            OP_SRA_B:  begin ctl.kind = SK_ARITH;  ctl.src = AS_REGB; end
            OP_NORM:   begin ctl.kind = SK_LOGIC;  ctl.src = AS_PENC; ctl.left = 1'b1;
                             ctl.norm = 1'b1; end
            OP_NORM_A: begin ctl.kind = SK_LOGIC;  ctl.src = AS_PENC; ctl.left = 1'b1;
                             ctl.norm = 1'b1; ctl.wr_a = 1'b1; end
            OP_NORM_B: begin ctl.kind = SK_LOGIC;  ctl.src = AS_PENC; ctl.left = 1'b1;
                             ctl.norm = 1'b1; ctl.wr_b = 1'b1; end
        endcase
    end

endmodule

// File: rtl/nsh_penc.sv
module nsh_penc #(
    parameter int W = 16,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    output logic [AW-1:0] cnt
);

    // Count of sign copies directly below the sign bit (at most W-1).
    always_comb begin
        logic stop;
        cnt  = '0;
        stop = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!stop) begin
                if (d[i] == d[W-1]) cnt = cnt + AW'(1);
                else                stop = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nsh_barrel.sv
module nsh_barrel
    import nsh_pkg::*;
#(
    parameter int W = 16,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  shk_e          kind,
    output logic [W-1:0]  dout
);

    logic [W-1:0] flip_in;
    logic [W-1:0] flip_out;
    logic [W-1:0] stg [AW+1];
    logic         fill;

    // Left moves reuse the right-moving stages on a bit-reversed word.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign flip_in[i]  = din[W-1-i];
        assign flip_out[i] = stg[AW][W-1-i];
    end

    assign fill   = (kind == SK_ARITH) ? din[W-1] : 1'b0;
    assign stg[0] = left ? flip_in : din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [W-1:0] moved;
        assign moved = (kind == SK_ROTATE) ? {stg[s][K-1:0], stg[s][W-1:K]}
                                           : {{K{fill}}, stg[s][W-1:K]};
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign dout = left ? flip_out : stg[AW];

endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
    import nsh_pkg::*;
#(
    parameter int W = 16,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [W-1:0]  data_in,
    input  logic [3:0]    op_in,
    input  logic [AW-1:0] amt_in,
    input  logic          amt_lock,
    output logic [AW-1:0] amt_out,
    output logic          amt_oe,
    output logic [W-1:0]  data_out
);

    // Stage 1: latched operation and operands
    op_e           op_q;
    logic [W-1:0]  din_q;
    logic [AW-1:0] amt_q;
    logic          lock_q;

    // Stage 2: result and amount registers
    logic [W-1:0]  dout_q;
    logic [AW-1:0] reg_a;
    logic [AW-1:0] reg_b;

    ctl_t          ctl;
    logic [AW-1:0] pe_cnt;
    logic [AW-1:0] sel_amt;
    logic [AW-1:0] shift_amt;
    logic [W-1:0]  shifted;

    always_ff @(posedge clk) begin
        if (clr) begin
            op_q   <= OP_SRL_V;
            din_q  <= '0;
            amt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            op_q   <= op_e'(op_in);
            din_q  <= data_in;
            amt_q  <= amt_in;
            lock_q <= amt_lock;
        end
    end

    nsh_decode u_dec (
        .op  (op_q),
        .ctl (ctl)
    );

    nsh_penc #(.W(W)) u_penc (
        .d   (din_q),
        .cnt (pe_cnt)
    );

    always_comb begin
        unique case (ctl.src)
            AS_PORT: sel_amt = amt_q;
            AS_REGA: sel_amt = reg_a;
            AS_REGB: sel_amt = reg_b;
            AS_PENC: sel_amt = pe_cnt;
        endcase
    end

    assign shift_amt = (ctl.kind == SK_PASS) ? '0 : sel_amt;

    nsh_barrel #(.W(W)) u_bar (
        .din  (din_q),
        .amt  (shift_amt),
        .left (ctl.left),
        .kind (ctl.kind),
        .dout (shifted)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            dout_q <= '0;
            reg_a  <= '0;
            reg_b  <= '0;
        end else begin
            dout_q <= shifted;
            if (ctl.wr_a) reg_a <= ctl.norm ? pe_cnt : amt_q;
            if (ctl.wr_b) reg_b <= ctl.norm ? pe_cnt : amt_q;
        end
    end

    assign data_out = dout_q;
    assign amt_oe   = ctl.norm & ~lock_q;
    assign amt_out  = amt_oe ? pe_cnt : '0;

endmodule

// File: rtl/nsh_chk.sv
module nsh_chk
    import nsh_pkg::*;
#(
    parameter int W = 16,
    localparam int AW = $clog2(W)
) (
    input logic          clk,
    input logic          clr,
    input op_e           op_q,
    input logic [W-1:0]  din_q,
    input logic [AW-1:0] amt_q,
    input logic          lock_q,
    input logic [AW-1:0] reg_a,
    input logic [AW-1:0] reg_b,
    input logic [W-1:0]  data_out,
    input logic          amt_oe
);

    logic is_norm;
    assign is_norm = (op_q == OP_NORM) || (op_q == OP_NORM_A) || (op_q == OP_NORM_B);

    p_port_dir_r9: assert property (@(posedge clk) disable iff (clr)
        amt_oe |-> (is_norm && !lock_q));

    p_port_quiet_r9: assert property (@(posedge clk) disable iff (clr)
        (lock_q || !is_norm) |-> !amt_oe);

    p_load_a_r6: assert property (@(posedge clk) disable iff (clr)
        (op_q == OP_LDA_V) |=> (reg_a == $past(amt_q)));

    p_load_b_r6: assert property (@(posedge clk) disable iff (clr)
        (op_q == OP_LDB_V) |=> (reg_b == $past(amt_q)));

    p_load_pass_r6: assert property (@(posedge clk) disable iff (clr)
        (op_q == OP_LDA_V || op_q == OP_LDB_V) |=> (data_out == $past(din_q)));

    p_hold_a_r8: assert property (@(posedge clk) disable iff (clr)
        !(op_q == OP_LDA_V || op_q == OP_NORM_A) |=> $stable(reg_a));

    p_hold_b_r8: assert property (@(posedge clk) disable iff (clr)
        !(op_q == OP_LDB_V || op_q == OP_NORM_B) |=> $stable(reg_b));

    p_norm_shape_r7: assert property (@(posedge clk) disable iff (clr)
        is_norm |=> (data_out == '0 || data_out[W-1] != data_out[W-2]));

    p_rot_weight_r3: assert property (@(posedge clk) disable iff (clr)
        (op_q == OP_ROR_V || op_q == OP_ROL_V)
            |=> ($countones(data_out) == $countones($past(din_q))));

    p_clear_r10: assert property (@(posedge clk)
        clr |=> (data_out == '0 && reg_a == '0 && reg_b == '0));

endmodule

bind norm_shifter nsh_chk #(.W(W)) u_chk (
    .clk      (clk),
    .clr      (clr),
    .op_q     (op_q),
    .din_q    (din_q),
    .amt_q    (amt_q),
    .lock_q   (lock_q),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .data_out (data_out),
    .amt_oe   (amt_oe)
);

// File: tb/tb_norm_shifter.sv
`timescale 1ns/1ps
module tb_norm_shifter;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [15:0] data_in = '0;
    logic [3:0]  op_in = '0;
    logic [3:0]  amt_in = '0;
    logic        amt_lock = 1'b0;
    logic [3:0]  amt_out;
    logic        amt_oe;
    logic [15:0] data_out;

    always #2 clk = ~clk;

    norm_shifter dut (
        .clk      (clk),
        .clr      (clr),
        .data_in  (data_in),
        .op_in    (op_in),
        .amt_in   (amt_in),
        .amt_lock (amt_lock),
        .amt_out  (amt_out),
        .amt_oe   (amt_oe),
        .data_out (data_out)
    );

    typedef struct { int due; logic [15:0] exp; string tag; } ditem_t;
    typedef struct { int due; logic oe; logic [3:0] val; string tag; } pitem_t;

    ditem_t qd[$];
    pitem_t qp[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int mdl_a = 0;
    int mdl_b = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares results when they fall due
    always @(negedge clk) begin
        while (qd.size() > 0 && qd[0].due == cyc) begin
            n_cmp++;
            if (data_out !== qd[0].exp) begin
                n_bad++;
                $display("FAIL %s: data_out got %h expected %h", qd[0].tag, data_out, qd[0].exp);
            end
            void'(qd.pop_front());
        end
        while (qp.size() > 0 && qp[0].due == cyc) begin
            n_cmp++;
            if (amt_oe !== qp[0].oe || amt_out !== qp[0].val) begin
                n_bad++;
                $display("FAIL %s: oe/out got %b/%h expected %b/%h",
                         qp[0].tag, amt_oe, amt_out, qp[0].oe, qp[0].val);
            end
            void'(qp.pop_front());
        end
    end

    function automatic int ref_norm(input logic [15:0] d);
        int c = 0;
        for (int i = 14; i >= 0; i--) begin
            if (d[i] != d[15]) break;
            c++;
        end
        return c;
    endfunction

    function automatic logic [15:0] rot_r(input logic [15:0] d, input int n);
        logic [31:0] w = {d, d} >> n;
        return w[15:0];
    endfunction

    // Driver: applies one operation and pushes its expected outcomes
    task automatic issue(input int op, input logic [15:0] d, input logic [3:0] v,
                         input logic lk, input string tag);
        logic [15:0] res;
        int c = ref_norm(d);
        int n = int'(v);
        case (op)
            0:  res = d >> n;
            1:  res = d << n;
            2:  res = rot_r(d, n);
            3:  res = rot_r(d, (16 - n) % 16);
            4:  res = d >> mdl_a;
            5:  res = d << mdl_a;
            6:  res = d >> mdl_b;
            7:  res = d << mdl_b;
            8:  res = d;
            9:  res = d;
            10: res = 16'($signed(d) >>> n);
            11: res = 16'($signed(d) >>> mdl_a);
            12: res = 16'($signed(d) >>> mdl_b);
            default: res = d << c;
        endcase
        @(negedge clk);
        op_in    = 4'(op);
        data_in  = d;
        amt_in   = v;
        amt_lock = lk;
        qd.push_back('{due: cyc + 2, exp: res, tag: tag});
        qp.push_back('{due: cyc + 1, oe: (op >= 13) && !lk,
                       val: ((op >= 13) && !lk) ? 4'(c) : 4'h0,
                       tag: {"R9 port after ", tag}});
        if (op == 8)  mdl_a = n;
        if (op == 9)  mdl_b = n;
        if (op == 14) mdl_a = c;
        if (op == 15) mdl_b = c;
    endtask

    task automatic idle(input int k);
        repeat (k) begin
            @(negedge clk);
            op_in = 4'd0; data_in = '0; amt_in = '0; amt_lock = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1;
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state after clear
        n_cmp++;
        if (data_out !== 16'h0 || amt_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got %h/%b expected 0000/0", data_out, amt_oe);
        end
        clr = 1'b0;

        // R1: back-to-back operations, one result per edge
        issue(1, 16'h0001, 4'd1, 1'b0, "R1 pipe a");
        issue(0, 16'h8000, 4'd3, 1'b0, "R1 pipe b");
        issue(2, 16'h00F1, 4'd4, 1'b0, "R1 pipe c");

        // R2 R3 R4: every amount, two patterns
        for (int n = 0; n < 16; n++) begin
            issue(0,  16'hB3C5, 4'(n), 1'b0, "R2 zero-fill right");
            issue(1,  16'hB3C5, 4'(n), 1'b0, "R2 zero-fill left");
            issue(2,  16'hB3C5, 4'(n), 1'b0, "R3 rotate right");
            issue(3,  16'hB3C5, 4'(n), 1'b0, "R3 rotate left");
            issue(10, 16'hB3C5, 4'(n), 1'b0, "R4 sign-fill right neg");
            issue(10, 16'h4A71, 4'(n), 1'b0, "R4 sign-fill right pos");
            issue(2,  16'h4A71, 4'(n), 1'b0, "R3 rotate right b");
            issue(1,  16'h4A71, 4'(n), 1'b0, "R2 zero-fill left b");
        end

        // R5 R6: loaded amounts used by the very next operation
        for (int v = 0; v < 16; v++) begin
            issue(8,  16'hC0DE, 4'(v), 1'b0, "R6 load A passes data");
            issue(4,  16'hF00F, 4'hF - 4'(v), 1'b0, "R5 right by A");
            issue(5,  16'hF00F, 4'h0, 1'b0, "R5 left by A");
            issue(11, 16'h8421, 4'h7, 1'b0, "R5 sign-fill by A");
            issue(9,  16'h1357, 4'(15 - v), 1'b0, "R6 load B passes data");
            issue(6,  16'hFFFF, 4'(v), 1'b0, "R5 right by B");
            issue(7,  16'hA5A5, 4'h3, 1'b0, "R5 left by B");
            issue(12, 16'h9000, 4'h1, 1'b0, "R5 sign-fill by B");
        end

        // R7 R9: normalise on zero, all ones and single bits
        issue(13, 16'h0000, 4'h5, 1'b0, "R7 normalise zero");
        issue(13, 16'hFFFF, 4'h5, 1'b0, "R7 normalise all ones");
        for (int i = 0; i < 16; i++) begin
            issue(13, 16'h0001 << i, 4'h0, 1'b0, "R7 normalise single bit");
            issue(13, ~(16'h0001 << i), 4'h0, 1'b0, "R7 normalise single zero");
        end
        issue(13, 16'h0F00, 4'h0, 1'b1, "R9 locked normalise");
        issue(13, 16'hF0F0, 4'h0, 1'b1, "R9 locked normalise b");
        issue(0,  16'h1234, 4'h2, 1'b0, "R9 quiet on shift");

        // R8: count stored only by its own codes
        issue(14, 16'h0040, 4'h0, 1'b0, "R8 normalise into A");
        issue(5,  16'h0001, 4'h9, 1'b0, "R8 A holds count");
        issue(13, 16'h0001, 4'h0, 1'b0, "R8 plain normalise");
        issue(5,  16'h0001, 4'h9, 1'b0, "R8 A unchanged by plain normalise");
        issue(15, 16'hFFE0, 4'h0, 1'b0, "R8 normalise into B");
        issue(7,  16'h0003, 4'h2, 1'b0, "R8 B holds count");
        issue(4,  16'h8000, 4'h2, 1'b0, "R8 A unchanged by B store");

        // R10: clear in mid-run
        idle(4);
        @(negedge clk);
        clr = 1'b1;
        qd.push_back('{due: cyc + 1, exp: 16'h0, tag: "R10 clear output"});
        @(negedge clk);
        clr = 1'b0;
        mdl_a = 0;
        mdl_b = 0;
        issue(5, 16'h1234, 4'h7, 1'b0, "R10 A cleared");
        issue(7, 16'h4321, 4'h7, 1'b0, "R10 B cleared");

        idle(4);
        finish_run();
    end

endmodule